// File: doc/BRIEF.md
# Sixteen-Lane Load Coalescer

This block accepts one load request on behalf of a group of sixteen lanes. Each lane supplies an active flag and a byte address. All lanes share one element size code. The block sorts the active lanes by the aligned memory segment their element falls in. The segment size grows with the element size: 32 bytes for single bytes, 64 bytes for halfwords and 128 bytes for words. For each distinct segment it issues exactly one memory transaction on a valid/ready output channel, at most one per cycle.

Every transaction carries a base address, a size code and a mask of the lanes it serves. Lanes that share an element, or that touch a segment in any order or at any stride, are served by that one transaction. Each transaction is shrunk to the smallest aligned window that still covers its lanes. A new request is taken only when the previous one has been fully handed off. A request with no active lane is absorbed at once and produces nothing.

Top module: `hwc_coalescer`

## Requirements
- R1: The element size code `req_esize` selects the element width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, and 3 is treated as 4 bytes. The address bits below the element width are ignored. The segment is 32, 64 or 128 bytes for 1, 2 or 4-byte elements respectively.
- R2: For each distinct aligned segment touched by the active lanes, exactly one transaction is issued. Its `txn_mask` (bit i for lane i) holds every active lane whose element lies in that segment. No lane is served twice.
- R3: Transactions are issued in order of the lowest-numbered active lane that is not yet served.
- R4: `txn_size` encodes the transaction width: 0 is 32 bytes, 1 is 64 bytes, 2 is 128 bytes. When all elements of a transaction lie in one aligned 32-byte region, the size is 32 bytes.
- R5: A 128-byte segment whose elements do not fit one 32-byte region, but do fit one aligned 64-byte half, gives a 64-byte transaction. Otherwise the transaction takes the full segment size.
- R6: `txn_addr` is aligned to the transaction width, and the window it opens contains every element in `txn_mask`.
- R7: Inactive lanes are ignored whatever their address. A request with no active lane issues no transaction, and `req_ready` is high again in the next cycle.
- R8: `req_ready` is high when idle. A request is accepted on a clock edge with `req_valid` and `req_ready` both high. If any lane is active, `txn_valid` rises after that edge and `req_ready` stays low until the cycle after the final transaction handshake.
- R9: While `txn_valid` is high and `txn_ready` is low, the transaction address, size and mask hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_active | input | LANES | Per-lane active flags |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits i*ADDR_W upward |
| req_esize | input | 2 | Element size code |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Memory side takes the transaction |
| txn_addr | output | ADDR_W | Transaction base address |
| txn_size | output | 2 | Transaction width code |
| txn_mask | output | LANES | Lanes served by the transaction |

## Verification
The bench builds the block with its default parameters: sixteen lanes, 32-bit addresses and a 32-byte base segment. It therefore exercises the three real segment widths and all three transaction widths. The directed requests cover contiguous, strided, duplicated, reordered, partly inactive and empty lane patterns. A long pseudo-random sweep packs addresses into a 512-byte window under random element sizes and random back-pressure. In that window, shared segments, split segments and every shrink outcome all occur often. The bench compares each handshake against a list of transactions computed arithmetically from the lane addresses.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

   typedef enum logic [1:0] {
      TSZ_32  = 2'd0,
      TSZ_64  = 2'd1,
      TSZ_128 = 2'd2
   } tsz_e;

   // element size code to segment step above the base segment (3 acts as 2)
   function automatic logic [1:0] seg_code(input logic [1:0] esz);
      return (esz == 2'd3) ? 2'd2 : esz;
   endfunction

endpackage

// File: rtl/hwc_leader.sv
module hwc_leader #(
   parameter int LANES  = 16,
   parameter int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0]  pend,
   output logic [LIDX_W-1:0] lead_idx
);

   generate
      if (LANES == 1) begin : g_single
         assign lead_idx = '0;
      end else begin : g_multi
         always_comb begin
            lead_idx = '0;
            for (int i = LANES - 1; i >= 0; i--) begin
               if (pend[i]) lead_idx = LIDX_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hwc_lane_match.sv
module hwc_lane_match #(
   parameter int LANES     = 16,
   parameter int ADDR_W    = 32,
   parameter int BASE_LOG2 = 5
) (
   input  logic [LANES*ADDR_W-1:0] addr_flat,
   input  logic [LANES-1:0]        pend,
   input  logic [1:0]              sc,
   input  logic [ADDR_W-1:0]       lead_addr,
   output logic [LANES-1:0]        match,
   output logic [2*LANES-1:0]      region_bits
);

   localparam int SHW = $clog2(ADDR_W + 1);

   logic [SHW-1:0]    seg_sh;
   logic [ADDR_W-1:0] lead_seg;

   assign seg_sh   = SHW'(BASE_LOG2) + SHW'(sc);
   assign lead_seg = lead_addr >> seg_sh;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         logic [ADDR_W-1:0] la;
         assign la = addr_flat[g*ADDR_W +: ADDR_W];
         assign match[g] = pend[g] && ((la >> seg_sh) == lead_seg);
         assign region_bits[2*g +: 2] = la[BASE_LOG2 +: 2];
      end
   endgenerate

endmodule

// File: rtl/hwc_size_sel.sv
module hwc_size_sel
   import hwc_pkg::*;
#(
   parameter int LANES     = 16,
   parameter int ADDR_W    = 32,
   parameter int BASE_LOG2 = 5
) (
   input  logic [LANES-1:0]   match,
   input  logic [2*LANES-1:0] region_bits,
   input  logic [1:0]         sc,
   input  logic [ADDR_W-1:0]  lead_addr,
   output logic [1:0]         tsz,
   output logic [ADDR_W-1:0]  base
);

   localparam int SHW = $clog2(ADDR_W + 1);

   logic seen0_lo, seen1_lo, seen0_hi, seen1_hi;
   logic same_lo, same_hi;
   tsz_e pick;
   logic [ADDR_W-1:0] low_mask;

   always_comb begin
      seen0_lo = 1'b0;
      seen1_lo = 1'b0;
      seen0_hi = 1'b0;
      seen1_hi = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         if (match[i]) begin
            if (region_bits[2*i])   seen1_lo = 1'b1;
            else                    seen0_lo = 1'b1;
            if (region_bits[2*i+1]) seen1_hi = 1'b1;
            else                    seen0_hi = 1'b1;
         end
      end
   end

   assign same_lo = !(seen0_lo && seen1_lo);
   assign same_hi = !(seen0_hi && seen1_hi);

   always_comb begin
      case (sc)
         2'd0:    pick = TSZ_32;
         2'd1:    pick = same_lo ? TSZ_32 : TSZ_64;
         default: begin
            if (same_lo && same_hi) pick = TSZ_32;
            else if (same_hi)       pick = TSZ_64;
            else                    pick = TSZ_128;
         end
      endcase
   end

   assign tsz      = pick;
   assign low_mask = (ADDR_W'(1) << (SHW'(BASE_LOG2) + SHW'(pick))) - ADDR_W'(1);
   assign base     = lead_addr & ~low_mask;

endmodule

// File: rtl/hwc_coalescer.sv
module hwc_coalescer
   import hwc_pkg::*;
#(
   parameter int LANES     = 16,
   parameter int ADDR_W    = 32,
   parameter int BASE_LOG2 = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [LANES-1:0]        req_active,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   input  logic [1:0]              req_esize,
   output logic                    txn_valid,
   input  logic                    txn_ready,
   output logic [ADDR_W-1:0]       txn_addr,
   output logic [1:0]              txn_size,
   output logic [LANES-1:0]        txn_mask
);

   localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   generate
      if (LANES < 1 || LANES > 64) begin : g_bad_lanes
         $error("hwc_coalescer: LANES out of range");
      end
      if (BASE_LOG2 < 2 || BASE_LOG2 + 3 > ADDR_W) begin : g_bad_base
         $error("hwc_coalescer: BASE_LOG2 does not fit ADDR_W");
      end
   endgenerate

   logic                    busy_q;
   logic [LANES-1:0]        pend_q;
   logic [LANES*ADDR_W-1:0] addr_q;
   logic [1:0]              sc_q;

   logic [LIDX_W-1:0]  lead_idx;
   logic [ADDR_W-1:0]  lead_addr;
   logic [LANES-1:0]   match;
   logic [2*LANES-1:0] region_bits;
   logic [1:0]         tsz;
   logic [ADDR_W-1:0]  base;
   logic               accept, handoff;
   logic [LANES-1:0]   pend_next;

   assign accept    = req_valid && !busy_q;
   assign handoff   = busy_q && txn_ready;
   assign pend_next = pend_q & ~match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= '0;
         addr_q <= '0;
         sc_q   <= 2'd0;
      end else if (accept) begin
         busy_q <= |req_active;
         pend_q <= req_active;
         addr_q <= req_addr;
         sc_q   <= seg_code(req_esize);
      end else if (handoff) begin
         busy_q <= |pend_next;
         pend_q <= pend_next;
      end
   end

   hwc_leader #(.LANES(LANES), .LIDX_W(LIDX_W)) u_leader (
      .pend     (pend_q),
      .lead_idx (lead_idx)
   );

   assign lead_addr = addr_q[lead_idx*ADDR_W +: ADDR_W];

   hwc_lane_match #(.LANES(LANES), .ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2)) u_match (
      .addr_flat   (addr_q),
      .pend        (pend_q),
      .sc          (sc_q),
      .lead_addr   (lead_addr),
      .match       (match),
      .region_bits (region_bits)
   );

   hwc_size_sel #(.LANES(LANES), .ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2)) u_size (
      .match       (match),
      .region_bits (region_bits),
      .sc          (sc_q),
      .lead_addr   (lead_addr),
      .tsz         (tsz),
      .base        (base)
   );

   assign req_ready = !busy_q;
   assign txn_valid = busy_q;
   assign txn_addr  = base;
   assign txn_size  = tsz;
   assign txn_mask  = match;

endmodule

// File: rtl/hwc_coalescer_chk.sv
module hwc_coalescer_chk #(
   parameter int LANES     = 16,
   parameter int ADDR_W    = 32,
   parameter int BASE_LOG2 = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [LANES-1:0]  req_active,
   input logic              txn_valid,
   input logic              txn_ready,
   input logic [ADDR_W-1:0] txn_addr,
   input logic [1:0]        txn_size,
   input logic [LANES-1:0]  txn_mask
);

   localparam int SHW = $clog2(ADDR_W + 1);

   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr)
                                     && $stable(txn_size) && $stable(txn_mask)));

   assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> !req_ready);

   assert_accept_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_active != '0)) |=> txn_valid);

   assert_empty_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_active == '0)) |=> (req_ready && !txn_valid));

   assert_mask_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> (txn_mask != '0));

   assert_no_reissue_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_ready) |=> (!txn_valid || ((txn_mask & $past(txn_mask)) == '0)));

   assert_size_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> (txn_size != 2'd3));

   assert_base_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> ((txn_addr & ((ADDR_W'(1) << (SHW'(BASE_LOG2) + SHW'(txn_size)))
                                  - ADDR_W'(1))) == '0));

endmodule

bind hwc_coalescer hwc_coalescer_chk #(
   .LANES(LANES), .ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_active (req_active),
   .txn_valid  (txn_valid),
   .txn_ready  (txn_ready),
   .txn_addr   (txn_addr),
   .txn_size   (txn_size),
   .txn_mask   (txn_mask)
);

// File: tb/hwc_coalescer_test.sv
`timescale 1ns/1ps
module hwc_coalescer_test;

   localparam int L = 16;
   localparam int AW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [L-1:0] req_active = '0;
   logic [L*AW-1:0] req_addr;
   logic [1:0] req_esize = 2'd0;
   logic txn_valid;
   logic txn_ready = 1'b1;
   logic [AW-1:0] txn_addr;
   logic [1:0] txn_size;
   logic [L-1:0] txn_mask;

   logic [AW-1:0] a [L];
   logic bp = 1'b0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [AW-1:0] exp_addr [L];
   logic [1:0]    exp_size [L];
   logic [L-1:0]  exp_mask [L];
   int nexp;

   always #10 clk = ~clk;

   always_comb begin
      for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = a[i];
   end

   hwc_coalescer uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_active(req_active), .req_addr(req_addr), .req_esize(req_esize),
      .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
      .txn_size(txn_size), .txn_mask(txn_mask)
   );

   task automatic check(input logic ok, input string tag, input logic [63:0] act,
                        input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // arithmetic model of the expected transaction list
   task automatic build_exp();
      logic [L-1:0] pend;
      int sl, eb, ld, szl;
      logic [AW-1:0] e, lo, hi;
      logic [L-1:0] m;
      pend = req_active;
      nexp = 0;
      sl = 5 + ((req_esize == 2'd3) ? 2 : int'(req_esize));
      eb = 1 << (sl - 5);
      while (pend != '0) begin
         ld = 0;
         for (int i = L - 1; i >= 0; i--) if (pend[i]) ld = i;
         m = '0;
         lo = '1;
         hi = '0;
         for (int i = 0; i < L; i++) begin
            if (pend[i] && ((a[i] >> sl) == (a[ld] >> sl))) begin
               m[i] = 1'b1;
               e = a[i] & ~AW'(eb - 1);
               if (e < lo) lo = e;
               if (e > hi) hi = e;
            end
         end
         if ((lo >> 5) == (hi >> 5))              szl = 5;
         else if (sl == 7 && (lo >> 6) == (hi >> 6)) szl = 6;
         else                                       szl = sl;
         exp_size[nexp] = 2'(szl - 5);
         exp_addr[nexp] = (lo >> szl) << szl;
         exp_mask[nexp] = m;
         pend = pend & ~m;
         nexp++;
      end
   endtask

   task automatic run_req(input string tag);
      int k, guard;
      logic first;
      build_exp();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      k = 0;
      guard = 0;
      first = 1'b1;
      forever begin
         if (first) begin
            if (nexp > 0)
               check(!req_ready && txn_valid, "R8 busy after accept",
                     {req_ready, txn_valid}, 2'b01);
            else
               check(req_ready && !txn_valid, "R7 empty request idle",
                     {req_ready, txn_valid}, 2'b10);
            first = 1'b0;
         end
         if (!txn_valid) begin
            check(req_ready, "R8 ready after last", req_ready, 1);
            break;
         end
         txn_ready = bp ? (($urandom % 3) != 0) : 1'b1;
         if (txn_ready) begin
            if (k >= nexp) begin
               check(1'b0, {tag, " R2 extra transaction"}, txn_mask, 0);
            end else begin
               check(txn_mask == exp_mask[k], {tag, " mask"}, txn_mask, exp_mask[k]);
               check(txn_size == exp_size[k], {tag, " size"}, txn_size, exp_size[k]);
               check(txn_addr == exp_addr[k], {tag, " R6 base"}, txn_addr, exp_addr[k]);
            end
            k++;
         end
         @(negedge clk);
         guard++;
         if (guard > 200) begin
            check(1'b0, {tag, " R8 request never completed"}, guard, 0);
            break;
         end
      end
      check(k == nexp, {tag, " R2 transaction count"}, k, nexp);
      txn_ready = 1'b1;
   endtask

   task automatic fill(input logic [AW-1:0] start, input int step);
      for (int i = 0; i < L; i++) a[i] = start + AW'(i * step);
   endtask

   initial begin
      for (int i = 0; i < L; i++) a[i] = '0;
      repeat (3) @(negedge clk);
      check(req_ready && !txn_valid, "R8 reset state", {req_ready, txn_valid}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !txn_valid, "R8 idle after reset", {req_ready, txn_valid}, 2'b10);

      // R4 halfwords packed into 32 bytes
      req_active = '1; req_esize = 2'd1; fill(32'h1000, 2);
      run_req("R4 halfword packed");
      check(nexp == 1 && exp_size[0] == 2'd0, "R4 model", nexp, 1);

      // R5 words packed into 64 bytes of a 128-byte segment
      req_esize = 2'd2; fill(32'h2000, 4);
      run_req("R5 word packed");
      // R2 stride of two words fills the segment
      fill(32'h3000, 8);
      run_req("R2 word stride");
      // R2 lanes pairing on shared elements
      for (int i = 0; i < L; i++) a[i] = 32'h4000 + AW'(4 * (i / 2));
      run_req("R2 shared elements");
      // R2 two halves in two segments
      req_esize = 2'd1;
      for (int i = 0; i < L; i++) a[i] = (i < 8) ? 32'h5000 + AW'(2 * i) : 32'h5040 + AW'(2 * i);
      run_req("R2 split segments");
      // R3 lane zero in higher segment goes first
      fill(32'h5000, 2); a[0] = 32'h5100; a[5] = 32'h5200;
      run_req("R3 leader order");
      // R7 empty request
      req_active = '0; fill(32'h1234, 64);
      run_req("R7 empty");
      // R7 inactive lanes with scattered addresses
      req_active = 16'h0088; req_esize = 2'd2;
      fill(32'h9000, 300); a[3] = 32'h6004; a[7] = 32'h6010;
      run_req("R7 inactive ignored");
      // R1 bytes at stride three cross a 32-byte segment
      req_active = '1; req_esize = 2'd0; fill(32'h6000, 3);
      run_req("R1 byte stride");
      // R1 code 3 behaves as words
      req_esize = 2'd3; fill(32'h7000, 4);
      run_req("R1 code three");
      // R1 low address bits ignored, R5 shrink to 64
      req_esize = 2'd2; fill(32'h701F, 0); a[9] = 32'h7021; a[10] = 32'h7022;
      run_req("R1 R5 low bits");

      // pseudo-random sweep with back-pressure, R9 checked via compares on stall
      bp = 1'b1;
      for (int r = 0; r < 1500; r++) begin
         req_esize = 2'($urandom % 4);
         req_active = 16'($urandom) | ((r % 4 == 0) ? 16'hFFFF : 16'h0);
         if (r % 37 == 0) req_active = '0;
         for (int i = 0; i < L; i++) a[i] = 32'h8000 + AW'($urandom % 512);
         run_req("R9 R3 random sweep");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule